// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives a serial clock for a synchronous serial master from its functional clock. The first stage is a prescaler shared by every chip select, dividing by 2, 4, 7 or 10. The second stage divides the prescaler pulses further by 2, 4 or 8, and its ratio is taken from the divider field of the chip select in use. Together the two stages set the serial clock period to the product of the two ratios, so the slowest clock is the functional clock divided by 80.

The block gives two outputs. `sck_o` is the serial clock level. `sck_edge_o` is a single-cycle strobe that is high in the same cycle as each change of `sck_o`, so the shift logic can act on it. While no transfer runs, the serial clock rests at the idle polarity level. All settings are captured only while the block is idle, so a transfer always runs at one fixed rate and never produces a short clock pulse.

Top module: `sck_clock_div`

## Requirements
- R1: `pre_sel_i` selects the prescaler ratio: 0 gives 2, 1 gives 4, 2 gives 7 and 3 gives 10.
- R2: The 2-bit divider field gives the second-stage ratio: 0 gives 2, 1 gives 4, 2 gives 8. The spare code 3 also gives 8.
- R3: During a transfer, `sck_o` toggles once every P*S/2 active cycles, where P is the prescaler ratio and S is the second-stage ratio. The first toggle follows the P*S/2-th active clock edge. A full serial clock period is therefore P*S cycles.
- R4: `sck_edge_o` is a single-cycle pulse in the cycle after each edge at which `sck_o` changed. No two pulses are ever adjacent. While the block is idle, `sck_o` equals `cpol_i` as sampled at the previous clock edge and `sck_edge_o` is low.
- R5: The divider field of chip select k sits at `cs_div_i[2k+1:2k]`. Only the field picked by `cs_sel_i` sets the second-stage ratio.
- R6: The block takes `pre_sel_i`, `cs_sel_i` and `cs_div_i` only at clock edges where it is idle. Changes made during a transfer leave the running serial clock period unchanged and apply from the next transfer.
- R7: The block runs only while both `run_i` and `enable_i` are high. With `enable_i` low it stays idle even when `run_i` is high.
- R8: While `rst_ni` is low, `sck_o` and `sck_edge_o` are low and the captured settings select the fastest ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable. When low, the divider is held idle |
| run_i | input | 1 | High while a transfer is active |
| pre_sel_i | input | 2 | Prescaler ratio index, shared by all chip selects |
| cs_sel_i | input | CS_W | Chip select in use |
| cs_div_i | input | 2*NUM_CS | Divider fields, one 2-bit field per chip select |
| cpol_i | input | 1 | Idle level of the serial clock |
| sck_o | output | 1 | Serial clock level |
| sck_edge_o | output | 1 | Single-cycle strobe for each serial clock change |

## Verification
The assertions check on every cycle:
- the idle level and the absence of strobes while the block is idle;
- that every strobe matches a change of `sck_o`, and that `sck_o` does not change without one;
- that strobes are never adjacent;
- that the captured settings stay stable during a transfer;
- that each half period has the length given by the captured ratios.

Only the bench scenarios can show the rest:
- that each of the twelve ratio pairs gives the full period it should;
- that the right chip select's field is used;
- that the spare code maps to 8;
- that settings changed during a transfer do not take effect until the next transfer starts.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;
  localparam int PRE_IDX_W = 2;
  localparam int FIELD_W   = 2;
  localparam int PRE_CNT_W = 4;
  localparam int POST_CNT_W = 3;

  typedef logic [PRE_IDX_W-1:0] pre_idx_t;
  typedef logic [FIELD_W-1:0]   field_t;

  function automatic logic [PRE_CNT_W-1:0] pre_ratio(input pre_idx_t idx);
    case (idx)
      2'd0:    pre_ratio = 4'd2;
      2'd1:    pre_ratio = 4'd4;
      2'd2:    pre_ratio = 4'd7;
      default: pre_ratio = 4'd10;
    endcase
  endfunction

  // half of the second-stage ratio, counted in prescaler ticks
  function automatic logic [POST_CNT_W-1:0] post_half(input field_t code);
    case (code)
      2'd0:    post_half = 3'd1;
      2'd1:    post_half = 3'd2;
      default: post_half = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/sck_div_cfg.sv
module sck_div_cfg
  import sck_div_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      hold_i,
  input  pre_idx_t                  pre_sel_i,
  input  logic [CS_W-1:0]           cs_sel_i,
  input  logic [FIELD_W*NUM_CS-1:0] cs_div_i,
  output pre_idx_t                  pre_q_o,
  output field_t                    div_q_o
);
  field_t fld [NUM_CS];

  for (genvar k = 0; k < NUM_CS; k++) begin : g_fld
    assign fld[k] = cs_div_i[k*FIELD_W +: FIELD_W];
  end

  // capture only at safe points: no transfer running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q_o <= '0;
      div_q_o <= '0;
    end else if (!hold_i) begin
      pre_q_o <= pre_sel_i;
      div_q_o <= fld[cs_sel_i];
    end
  end
endmodule

// File: rtl/sck_div_prescale.sv
module sck_div_prescale
  import sck_div_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  pre_idx_t sel_i,
  output logic     tick_o
);
  logic [PRE_CNT_W-1:0] cnt_q;
  logic [PRE_CNT_W-1:0] last;

  assign last   = pre_ratio(sel_i) - 4'd1;
  assign tick_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 4'd1;
  end
endmodule

// File: rtl/sck_div_post.sv
module sck_div_post
  import sck_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   tick_i,
  input  field_t code_i,
  input  logic   idle_lvl_i,
  output logic   sck_o,
  output logic   edge_o
);
  logic [POST_CNT_W-1:0] cnt_q;
  logic [POST_CNT_W-1:0] last;
  logic                  wrap;

  assign last = post_half(code_i) - 3'd1;
  assign wrap = tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sck_o  <= 1'b0;
      edge_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sck_o  <= idle_lvl_i;
      edge_o <= 1'b0;
    end else begin
      edge_o <= wrap;
      if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 3'd1;
      if (wrap)   sck_o <= ~sck_o;
    end
  end
endmodule

// File: rtl/sck_clock_div.sv
module sck_clock_div
  import sck_div_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      enable_i,
  input  logic                      run_i,
  input  logic [PRE_IDX_W-1:0]      pre_sel_i,
  input  logic [CS_W-1:0]           cs_sel_i,
  input  logic [FIELD_W*NUM_CS-1:0] cs_div_i,
  input  logic                      cpol_i,
  output logic                      sck_o,
  output logic                      sck_edge_o
);
  logic     active;
  logic     tick;
  pre_idx_t pre_q;
  field_t   div_q;

  assign active = run_i && enable_i;

  sck_div_cfg #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (active),
    .pre_sel_i(pre_sel_i),
    .cs_sel_i (cs_sel_i),
    .cs_div_i (cs_div_i),
    .pre_q_o  (pre_q),
    .div_q_o  (div_q)
  );

  sck_div_prescale u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (active),
    .sel_i (pre_q),
    .tick_o(tick)
  );

  sck_div_post u_post (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (active),
    .tick_i    (tick),
    .code_i    (div_q),
    .idle_lvl_i(cpol_i),
    .sck_o     (sck_o),
    .edge_o    (sck_edge_o)
  );
endmodule

// File: rtl/sck_clock_div_chk.sv
module sck_clock_div_chk
  import sck_div_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     enable_i,
  input logic     run_i,
  input logic     cpol_i,
  input logic     sck_o,
  input logic     sck_edge_o,
  input pre_idx_t pre_q,
  input field_t   div_q
);
  logic       act;
  logic [6:0] gap_q;
  logic [6:0] half_exp;

  assign act      = run_i && enable_i;
  assign half_exp = 7'(int'(pre_ratio(pre_q)) * int'(post_half(div_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gap_q <= '0;
    else if (!act)       gap_q <= '0;
    else if (sck_edge_o) gap_q <= 7'd1;
    else                 gap_q <= gap_q + 7'd1;
  end

  p_idle_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> (sck_o == $past(cpol_i)) && !sck_edge_o);

  p_edge_is_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_edge_o |-> (sck_o != $past(sck_o)));

  p_no_silent_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(act) && !sck_edge_o) |-> $stable(sck_o));

  p_edge_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_edge_o |=> !sck_edge_o);

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && $past(act)) |-> ($stable(pre_q) && $stable(div_q)));

  p_half_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_edge_o |-> (gap_q == half_exp));
endmodule

bind sck_clock_div sck_clock_div_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .run_i     (run_i),
  .cpol_i    (cpol_i),
  .sck_o     (sck_o),
  .sck_edge_o(sck_edge_o),
  .pre_q     (pre_q),
  .div_q     (div_q)
);

// File: tb/tb_sck_clock_div.sv
`timescale 1ns/1ps
module tb_sck_clock_div;
  localparam int NUM_CS = 4;
  localparam int CS_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, run = 1'b0, cpol = 1'b0;
  logic [1:0] pre_sel = 2'd0;
  logic [CS_W-1:0] cs_sel = '0;
  logic [2*NUM_CS-1:0] cs_div = '0;
  logic sck, sck_edge;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sck_clock_div #(.NUM_CS(NUM_CS), .CS_W(CS_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .run_i(run),
    .pre_sel_i(pre_sel), .cs_sel_i(cs_sel), .cs_div_i(cs_div),
    .cpol_i(cpol), .sck_o(sck), .sck_edge_o(sck_edge)
  );

  function automatic int pre_r(input int idx);
    case (idx) 0: return 2; 1: return 4; 2: return 7; default: return 10; endcase
  endfunction
  function automatic int post_r(input int code);
    case (code) 0: return 2; 1: return 4; default: return 8; endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  int m_cnt, m_pre, m_code;
  bit m_sck, m_edge;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sck = 0; m_edge = 0; m_cnt = 0; m_pre = 0; m_code = 0;
    end else if (!(run && en)) begin
      m_sck = cpol; m_edge = 0; m_cnt = 0;
      m_pre = pre_sel; m_code = cs_div[2*cs_sel +: 2];
    end else begin
      m_cnt++;
      if (m_cnt == pre_r(m_pre) * post_r(m_code) / 2) begin
        m_sck = !m_sck; m_edge = 1; m_cnt = 0;
      end else m_edge = 0;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(sck == m_sck, "R3/R4 model sck", sck, m_sck);
    chk(sck_edge == m_edge, "R3/R4 model edge", sck_edge, m_edge);
  end

  task automatic idle_set(input int pre, input int cs, input int code, input bit pol);
    @(negedge clk);
    run = 0;
    pre_sel = pre[1:0];
    cs_sel = cs[CS_W-1:0];
    cs_div = '1;
    cs_div[2*cs +: 2] = code[1:0];
    cpol = pol;
    repeat (2) @(negedge clk);
  endtask

  // period between the 2nd and 3rd toggle away from the idle level
  task automatic measure(output int per);
    int n = 0, t = 0, t1 = 0;
    bit prev = sck;
    per = -1;
    for (int i = 0; i < 400 && n < 3; i++) begin
      @(negedge clk); t++;
      if (sck != prev && sck != cpol) begin
        n++;
        if (n == 2) t1 = t;
        if (n == 3) per = t - t1;
      end
      prev = sck;
    end
  endtask

  initial begin
    int per;
    repeat (3) @(negedge clk);
    chk(sck == 1'b0, "R8 reset sck", sck, 0);
    chk(sck_edge == 1'b0, "R8 reset edge", sck_edge, 0);
    rst_n = 1; en = 1;
    @(negedge clk);

    // all twelve ratio pairs, rotating the chip select (R1 R2 R5)
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 3; c++) begin
        idle_set(p, (p + c) % NUM_CS, c, 1'b0);
        run = 1;
        measure(per);
        chk(per == pre_r(p) * post_r(c), "R1 R2 R5 period", per, pre_r(p) * post_r(c));
      end

    // spare code 3 behaves as 8 (R2)
    idle_set(1, 2, 3, 1'b0);
    run = 1; measure(per);
    chk(per == 32, "R2 spare code", per, 32);

    // idle polarity high (R4)
    idle_set(0, 1, 1, 1'b1);
    chk(sck == 1'b1, "R4 idle high", sck, 1);
    run = 1; measure(per);
    chk(per == 8, "R4 inverted period", per, 8);

    // change settings mid-transfer: ignored until next idle (R6)
    idle_set(0, 0, 0, 1'b0);
    run = 1;
    repeat (5) @(negedge clk);
    pre_sel = 2'd3; cs_div = '0; cs_div[1:0] = 2'd2;
    measure(per);
    chk(per == 4, "R6 mid-run ignored", per, 4);
    @(negedge clk); run = 0;
    repeat (2) @(negedge clk);
    run = 1; measure(per);
    chk(per == 80, "R6 applied after idle", per, 80);

    // enable low holds idle even with run high (R7)
    idle_set(0, 0, 0, 1'b1);
    en = 0; run = 1;
    begin
      int edges = 0;
      bit low_seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sck_edge) edges++;
        if (!sck) low_seen = 1;
      end
      chk(edges == 0, "R7 no strobes when disabled", edges, 0);
      chk(!low_seen, "R7 level held", low_seen, 0);
    end
    en = 1; measure(per);
    chk(per == 4, "R7 resumes", per, 4);

    @(negedge clk); run = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule